// File: doc/BRIEF.md
# Multi-PHY Cell Receive Buffer

This block is the receive master of a byte-wide ATM cell bus that serves several PHY devices. It drives a PHY address and polls each configured PHY in turn for a cell-available indication. When the addressed PHY reports a cell and a whole cell slot is free, the block asserts its active-low enable. It then takes the complete cell in one unbroken burst, one byte per clock, into a two-cell internal store.

A downstream consumer drains the store through a byte-wide pop port. The port marks the first and last byte of every cell and tags each cell with the number of the PHY that supplied it. One sticky event flag records two faults: a burst whose first byte lacks the start-of-cell mark, and a pop while no cell is held. The flag stays set until software pulses the clear input.

Top module: `mphy_cell_rx`

## Requirements
- R1: A burst begins (enable driven low) only in the cycle after the polled PHY showed cell-available high. The PHY address holds that PHY's number for the whole burst.
- R2: A good burst keeps the enable low for exactly CELL_BYTES consecutive cycles. The byte on the data input is captured on each of those clock edges.
- R3: The start-of-cell input must be 1 on the first byte of a burst. If it is 0, the burst ends after that single cycle, no cell is stored and the event flag is set.
- R4: While idle, the PHY address steps round-robin through 0..NUM_PHY-1 and wraps to 0. It never reaches NUM_PHY or above, so unused address bits stay 0.
- R5: The store holds at most two cells. With two cells held, no burst starts even when a PHY reports a cell.
- R6: The pop port presents the bytes of a cell in arrival order. The first-byte marker is high only on byte 0, the last-byte marker only on byte CELL_BYTES-1, and the PHY tag equals the source PHY. pop_valid_o is high while at least one cell is held.
- R7: A pop while pop_valid_o is low sets the event flag. The flag stays set until evt_clr_i is high for a cycle, and a new fault in that same cycle wins over the clear.
- R8: Cells leave the pop port in the order in which their bursts finished.
- R9: After reset the enable is high, the address is 0, pop_valid_o is 0 and the event flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phy_data_i | input | 8 | Cell byte from the addressed PHY |
| phy_soc_i | input | 1 | Start-of-cell mark from the PHY |
| phy_clav_i | input | 1 | Cell-available from the addressed PHY |
| phy_enb_no | output | 1 | Receive enable to the PHY, active low |
| phy_addr_o | output | 5 | Polled or selected PHY number |
| pop_i | input | 1 | Consume the presented byte |
| pop_valid_o | output | 1 | A stored cell is being presented |
| pop_data_o | output | 8 | Presented byte |
| pop_first_o | output | 1 | Presented byte is the first of its cell |
| pop_last_o | output | 1 | Presented byte is the last of its cell |
| pop_phy_o | output | 5 | Source PHY of the presented cell |
| evt_clr_i | input | 1 | Clear the sticky event flag |
| evt_o | output | 1 | Sticky fault flag: bad start or pop underrun |

## Verification
The bench builds the block with CELL_BYTES=8 and NUM_PHY=5. The short cell keeps each burst and each full drain of the store to a few cycles, so both slots fill and wrap many times within a short run. A PHY count that is not a power of two makes the address wrap from 4 to 0 visible, and the 3-bit PHY number fits into each data byte, so a byte taken from the wrong PHY or at the wrong offset shows up as a data mismatch.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  typedef enum logic {ST_POLL, ST_XFER} rx_state_e;
endpackage

// File: rtl/mcr_poller.sv
module mcr_poller
  import mcr_pkg::*;
#(
  parameter int NUM_PHY = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] LastAddr = ADDR_W'(NUM_PHY - 1);

  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (step_i) ptr_q <= (ptr_q == LastAddr) ? '0 : ptr_q + 1'b1;
  end

  assign addr_o = ptr_q;
endmodule

// File: rtl/mcr_store.sv
module mcr_store
  import mcr_pkg::*;
#(
  parameter int CELL_BYTES = 53
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [$clog2(CELL_BYTES)-1:0] wr_idx_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic                          commit_i,
  input  logic [ADDR_W-1:0]             commit_phy_i,
  input  logic                          pop_i,
  output logic                          full_o,
  output logic                          valid_o,
  output logic [DATA_W-1:0]             data_o,
  output logic                          first_o,
  output logic                          last_o,
  output logic [ADDR_W-1:0]             phy_o,
  output logic                          underrun_o
);
  localparam int IW = $clog2(CELL_BYTES);
  localparam int NSLOT = 2;
  localparam logic [IW-1:0] LastIdx = IW'(CELL_BYTES - 1);

  logic              wr_slot_q, rd_slot_q;
  logic [IW-1:0]     rd_idx_q;
  logic [1:0]        cnt_q;
  logic [DATA_W-1:0] slot_byte [NSLOT];
  logic [ADDR_W-1:0] slot_phy  [NSLOT];
  logic              pop_ok, release_slot;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [DATA_W-1:0] mem [CELL_BYTES];
    logic [ADDR_W-1:0] phy_q;

    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_slot_q == 1'(s))) mem[wr_idx_i] <= wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) phy_q <= '0;
      else if (commit_i && (wr_slot_q == 1'(s))) phy_q <= commit_phy_i;
    end

    assign slot_byte[s] = mem[rd_idx_q];
    assign slot_phy[s]  = phy_q;
  end

  assign valid_o      = (cnt_q != 2'd0);
  assign full_o       = (cnt_q == 2'd2);
  assign pop_ok       = pop_i && valid_o;
  assign release_slot = pop_ok && (rd_idx_q == LastIdx);
  assign underrun_o   = pop_i && !valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_slot_q <= 1'b0;
      rd_slot_q <= 1'b0;
      rd_idx_q  <= '0;
      cnt_q     <= 2'd0;
    end else begin
      if (commit_i) wr_slot_q <= ~wr_slot_q;
      if (pop_ok) begin
        if (release_slot) begin
          rd_idx_q  <= '0;
          rd_slot_q <= ~rd_slot_q;
        end else begin
          rd_idx_q <= rd_idx_q + 1'b1;
        end
      end
      cnt_q <= cnt_q + {1'b0, commit_i} - {1'b0, release_slot};
    end
  end

  assign data_o  = slot_byte[rd_slot_q];
  assign phy_o   = slot_phy[rd_slot_q];
  assign first_o = valid_o && (rd_idx_q == '0);
  assign last_o  = valid_o && (rd_idx_q == LastIdx);
endmodule

// File: rtl/mphy_cell_rx.sv
module mphy_cell_rx
  import mcr_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int NUM_PHY    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        phy_data_i,
  input  logic              phy_soc_i,
  input  logic              phy_clav_i,
  output logic              phy_enb_no,
  output logic [4:0]        phy_addr_o,
  input  logic              pop_i,
  output logic              pop_valid_o,
  output logic [7:0]        pop_data_o,
  output logic              pop_first_o,
  output logic              pop_last_o,
  output logic [4:0]        pop_phy_o,
  input  logic              evt_clr_i,
  output logic              evt_o
);
  localparam int IW = $clog2(CELL_BYTES);
  localparam logic [IW-1:0] LastIdx = IW'(CELL_BYTES - 1);

  rx_state_e         state_q;
  logic [IW-1:0]     idx_q;
  logic [ADDR_W-1:0] addr;
  logic              full, underrun, evt_q;
  logic              start, abort, done, step, in_xfer;

  assign in_xfer = (state_q == ST_XFER);
  assign start   = !in_xfer && phy_clav_i && !full;
  assign abort   = in_xfer && (idx_q == '0) && !phy_soc_i;
  assign done    = in_xfer && (idx_q == LastIdx) && !abort;
  // poll pointer moves on when idle and not starting, or when a burst ends
  assign step    = (!in_xfer && !start) || abort || done;

  mcr_poller #(.NUM_PHY(NUM_PHY)) u_poller (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .addr_o (addr)
  );

  mcr_store #(.CELL_BYTES(CELL_BYTES)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (in_xfer),
    .wr_idx_i     (idx_q),
    .wr_data_i    (phy_data_i),
    .commit_i     (done),
    .commit_phy_i (addr),
    .pop_i        (pop_i),
    .full_o       (full),
    .valid_o      (pop_valid_o),
    .data_o       (pop_data_o),
    .first_o      (pop_first_o),
    .last_o       (pop_last_o),
    .phy_o        (pop_phy_o),
    .underrun_o   (underrun)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_POLL;
      idx_q   <= '0;
      evt_q   <= 1'b0;
    end else begin
      evt_q <= (evt_q && !evt_clr_i) || abort || underrun;
      if (!in_xfer) begin
        idx_q <= '0;
        if (start) state_q <= ST_XFER;
      end else if (abort || done) begin
        idx_q   <= '0;
        state_q <= ST_POLL;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign phy_enb_no = !in_xfer;
  assign phy_addr_o = addr;
  assign evt_o      = evt_q;
endmodule

// File: rtl/mphy_cell_rx_chk.sv
module mphy_cell_rx_chk #(
  parameter int CELL_BYTES = 53,
  parameter int NUM_PHY    = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       phy_clav_i,
  input logic       phy_enb_no,
  input logic [4:0] phy_addr_o,
  input logic       pop_i,
  input logic       pop_valid_o,
  input logic       pop_first_o,
  input logic       pop_last_o,
  input logic       evt_clr_i,
  input logic       evt_o
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          low_cnt <= '0;
    else if (!phy_enb_no) low_cnt <= low_cnt + 1'b1;
    else                  low_cnt <= '0;
  end

  // R1
  start_after_clav_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phy_enb_no) |-> $past(phy_clav_i));
  // R1
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phy_enb_no && $past(!phy_enb_no)) |-> $stable(phy_addr_o));
  // R2
  burst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_cnt <= 16'(CELL_BYTES));
  // R4
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_addr_o < 5'(NUM_PHY));
  // R6
  marker_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_first_o || pop_last_o) |-> pop_valid_o);
  // R7
  evt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && !evt_clr_i) |=> evt_o);
  // R7
  underrun_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !pop_valid_o) |=> evt_o);
endmodule

bind mphy_cell_rx mphy_cell_rx_chk #(.CELL_BYTES(CELL_BYTES), .NUM_PHY(NUM_PHY)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .phy_clav_i  (phy_clav_i),
  .phy_enb_no  (phy_enb_no),
  .phy_addr_o  (phy_addr_o),
  .pop_i       (pop_i),
  .pop_valid_o (pop_valid_o),
  .pop_first_o (pop_first_o),
  .pop_last_o  (pop_last_o),
  .evt_clr_i   (evt_clr_i),
  .evt_o       (evt_o)
);

// File: tb/mphy_cell_rx_bench.sv
module mphy_cell_rx_bench;
  localparam int CB = 8;
  localparam int NP = 5;
  localparam int NV = 5;
  // [3] start mark good, [2:0] PHY
  localparam logic [3:0] VEC [NV] = '{4'b1000, 4'b1011, 4'b1100, 4'b0010, 4'b1001};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] phy_data = '0;
  logic       phy_soc = 1'b0;
  logic       phy_clav;
  logic       enb_n;
  logic [4:0] phy_addr;
  logic       pop = 1'b0;
  logic       pop_valid, pop_first, pop_last, evt;
  logic [7:0] pop_data;
  logic [4:0] pop_phy;
  logic       evt_clr = 1'b0;

  bit has [NP];
  bit bad [NP];
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mphy_cell_rx #(.CELL_BYTES(CB), .NUM_PHY(NP)) u_mphy_cell_rx (
    .clk_i(clk), .rst_ni(rst_n), .phy_data_i(phy_data), .phy_soc_i(phy_soc),
    .phy_clav_i(phy_clav), .phy_enb_no(enb_n), .phy_addr_o(phy_addr),
    .pop_i(pop), .pop_valid_o(pop_valid), .pop_data_o(pop_data),
    .pop_first_o(pop_first), .pop_last_o(pop_last), .pop_phy_o(pop_phy),
    .evt_clr_i(evt_clr), .evt_o(evt)
  );

  assign phy_clav = (phy_addr < 5'(NP)) ? has[phy_addr] : 1'b0;

  // PHY model: presents the next byte at each falling edge while enabled
  initial begin
    int idx;
    idx = 0;
    forever begin
      @(negedge clk);
      if (!rst_n || enb_n) begin
        idx = 0;
        phy_soc = 1'b0;
      end else begin
        automatic int a = int'(phy_addr);
        phy_soc  = (idx == 0) && !bad[a];
        phy_data = {3'(a), 5'(idx)};
        if (idx == 0 && bad[a]) begin
          bad[a] = 1'b0;
          has[a] = 1'b0;
        end
        idx++;
        if (idx == CB) has[a] = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic wait_xfer(input int phy, input int exp_len);
    int t = 0;
    int lows = 0;
    while (enb_n && t < 100) begin @(negedge clk); t++; end
    while (!enb_n && t < 200) begin
      chk(phy_addr == 5'(phy), "R1 address during burst", int'(phy_addr), phy);
      lows++;
      @(negedge clk);
      t++;
    end
    chk(lows == exp_len, "R2 burst length", lows, exp_len);
  endtask

  task automatic pop_cell(input int phy, input string req);
    for (int b = 0; b < CB; b++) begin
      @(negedge clk);
      chk(pop_valid == 1'b1, {req, " R6 valid"}, int'(pop_valid), 1);
      chk(pop_data == {3'(phy), 5'(b)}, {req, " R6 data"}, int'(pop_data), int'({3'(phy), 5'(b)}));
      chk(pop_first == (b == 0), {req, " R6 first"}, int'(pop_first), int'(b == 0));
      chk(pop_last == (b == CB - 1), {req, " R6 last"}, int'(pop_last), int'(b == CB - 1));
      chk(pop_phy == 5'(phy), {req, " R6 phy"}, int'(pop_phy), phy);
      pop = 1'b1;
    end
    @(negedge clk);
    pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(enb_n == 1'b1, "R9 enable", int'(enb_n), 1);
    chk(phy_addr == 5'd0, "R9 address", int'(phy_addr), 0);
    chk(pop_valid == 1'b0, "R9 valid", int'(pop_valid), 0);
    chk(evt == 1'b0, "R9 event", int'(evt), 0);
    rst_n = 1'b1;

    // R4 round-robin stepping with wrap
    @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      automatic int prev = int'(phy_addr);
      @(negedge clk);
      chk(int'(phy_addr) == (prev + 1) % NP, "R4 poll order", int'(phy_addr), (prev + 1) % NP);
    end

    // vector table
    for (int v = 0; v < NV; v++) begin
      automatic int  p    = int'(VEC[v][2:0]);
      automatic bit  good = VEC[v][3];
      bad[p] = !good;
      has[p] = 1'b1;
      wait_xfer(p, good ? CB : 1);
      @(negedge clk);
      if (good) begin
        chk(evt == 1'b0, "R3 no event on good cell", int'(evt), 0);
        pop_cell(p, "vector");
        @(negedge clk);
        chk(pop_valid == 1'b0, "R6 empty after drain", int'(pop_valid), 0);
      end else begin
        chk(evt == 1'b1, "R3 bad start flagged", int'(evt), 1);
        chk(pop_valid == 1'b0, "R3 bad cell dropped", int'(pop_valid), 0);
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
        chk(evt == 1'b0, "R7 clear", int'(evt), 0);
      end
    end

    // R5 two-slot limit, R8 ordering
    has[1] = 1'b1;
    wait_xfer(1, CB);
    has[3] = 1'b1;
    wait_xfer(3, CB);
    has[0] = 1'b1;
    begin
      int lows = 0;
      for (int i = 0; i < 4 * NP; i++) begin
        @(negedge clk);
        if (!enb_n) lows++;
      end
      chk(lows == 0, "R5 no burst while full", lows, 0);
      chk(has[0] == 1'b1, "R5 cell left in PHY", int'(has[0]), 1);
    end
    pop_cell(1, "R8 first cell");
    wait_xfer(0, CB);
    pop_cell(3, "R8 second cell");
    pop_cell(0, "R8 third cell");

    // R7 underrun and stickiness
    @(negedge clk);
    chk(evt == 1'b0, "R7 idle no event", int'(evt), 0);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    chk(evt == 1'b1, "R7 underrun sets event", int'(evt), 1);
    repeat (5) @(negedge clk);
    chk(evt == 1'b1, "R7 event sticky", int'(evt), 1);
    evt_clr = 1'b1;
    @(negedge clk);
    evt_clr = 1'b0;
    chk(evt == 1'b0, "R7 event cleared", int'(evt), 0);
    // clear and fault in the same cycle: fault wins
    evt_clr = 1'b1;
    pop = 1'b1;
    @(negedge clk);
    evt_clr = 1'b0;
    pop = 1'b0;
    chk(evt == 1'b1, "R7 fault beats clear", int'(evt), 1);

    finish_run();
  end
endmodule